// File: doc/BRIEF.md
# Class-Latency Result Scoreboard

This block tracks, for every architectural destination register, how many cycles remain before the value being produced for it can be consumed. When an instruction issues on one of the issue lanes, the block looks up the result latency of the instruction's class and loads a per-register countdown with that latency minus one. Waiting instructions present their source registers as queries, and the block answers each one with a ready flag. It also raises a single stall whenever any valid source is not yet ready.

Readiness depends on both ends of the dependence. Some producer/consumer class pairs forward a result one cycle earlier than the producer's full latency. Wide (128-bit) SIMD consumers read the upper half of an operand one cycle late, so a wide SIMD move or add that feeds another wide SIMD move or add can start early. Register 0 is hard-wired and is never tracked. A query marked invalid never causes a stall. Instruction decode, the register file and the forwarding datapath are outside this block.

Top module: `cls_lat_scoreboard`

## Requirements
- R1: After reset every register is ready: any valid query to registers 1..NREGS-1 returns ready and `stall` is 0.
- R2: A register written by an instruction of class code C is not ready for a consumer issuing in cycle issue+L-1 and is ready in cycle issue+L. L is given by code: 0 simple ALU/shift=1, 1 ALU with shifted/extended operand=2, 2 conditional select=2, 3 integer multiply=4, 4 integer divide=22, 5 scalar load=3, 6 FP/SIMD 64-bit load=4, 7 wide SIMD load pair=4, 8 FP add=4, 9 FP multiply/accumulate=6, 10 FP/integer convert=6, 11 FP move/min/max/select/abs/neg=2, 12 FP round-to-integral=4, 13 FP divide single=12, 14 FP divide double=22, 15 FP square root single=17, 16 FP square root double=28, 17 SIMD move/logic=2, 18 wide SIMD move/logic=3, 19 SIMD add/compare=4, 20 wide SIMD add/compare=5.
- R3: Any class code from 21 to 31 is treated as latency 1, like code 0.
- R4: When a new writer issues to a register that is still pending, the countdown takes the new writer's latency, whether that is shorter or longer than what remained.
- R5: With a producer of code 18 and a consumer of code 18 or 20, the distance is 2 cycles. With a producer of code 20 and a consumer of code 18 or 20, the distance is 4 cycles. Every other pair, such as producer 20 with consumer 19, uses the full latency of R2.
- R6: A valid query to register 0 is always ready, and an issue with destination 0 has no effect on it.
- R7: A query whose valid bit is 0 reports ready and does not contribute to `stall`, whatever register it names.
- R8: When lanes issue to the same destination in one cycle, the highest-numbered lane sets the countdown.
- R9: `stall` is 1 exactly when at least one valid query is not ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_vld | input | NISS | Per-lane issue valid |
| iss_dst | input | NISS×RW | Per-lane destination register |
| iss_cls | input | NISS×5 | Per-lane producer class code (R2) |
| src_vld | input | NSRC | Per-query valid |
| src_reg | input | NSRC×RW | Per-query source register |
| src_cls | input | NSRC×5 | Class code of the consuming instruction |
| src_rdy | output | NSRC | Per-query ready flag, combinational from current state |
| stall | output | 1 | Any valid query not ready |

## Verification
A wrong countdown shows at the ports as a ready flag that rises one or more cycles early or late after an issue. The bench catches this by sampling exactly in cycles issue+L-1 and issue+L for every class and every forwarding pair. A wrongly stored producer class only shows once the countdown has fallen to the forwarding slack, when a wide SIMD consumer is released one cycle off. A bad lane-priority or overwrite decision shows on the first query after the issue, because a long divide and a 1-cycle ALU op differ there by about twenty cycles.

// File: rtl/lat_sb_pkg.sv
package lat_sb_pkg;

  localparam int CW    = 5;   // class code width
  localparam int CNT_W = 5;   // countdown width, holds longest latency minus one
  localparam int LAT_W = 6;

  typedef enum logic [CW-1:0] {
    K_ALU    = 5'd0,  K_ALUX   = 5'd1,  K_CSEL   = 5'd2,  K_IMUL  = 5'd3,
    K_IDIV   = 5'd4,  K_LD     = 5'd5,  K_FLD    = 5'd6,  K_VLDP  = 5'd7,
    K_FADD   = 5'd8,  K_FMUL   = 5'd9,  K_FCVT   = 5'd10, K_FMOV  = 5'd11,
    K_FRND   = 5'd12, K_FDIVS  = 5'd13, K_FDIVD  = 5'd14, K_FSQS  = 5'd15,
    K_FSQD   = 5'd16, K_VMOV   = 5'd17, K_VMOVW  = 5'd18, K_VADD  = 5'd19,
    K_VADDW  = 5'd20
  } op_kind_e;

  // Full result latency of a producer class.
  function automatic logic [LAT_W-1:0] kind_latency(input logic [CW-1:0] k);
    case (k)
      K_ALUX, K_CSEL, K_FMOV, K_VMOV:               kind_latency = 6'd2;
      K_LD, K_VMOVW:                                kind_latency = 6'd3;
      K_IMUL, K_FLD, K_VLDP, K_FADD, K_FRND, K_VADD: kind_latency = 6'd4;
      K_VADDW:                                      kind_latency = 6'd5;
      K_FMUL, K_FCVT:                               kind_latency = 6'd6;
      K_FDIVS:                                      kind_latency = 6'd12;
      K_FSQS:                                       kind_latency = 6'd17;
      K_IDIV, K_FDIVD:                              kind_latency = 6'd22;
      K_FSQD:                                       kind_latency = 6'd28;
      default:                                      kind_latency = 6'd1;
    endcase
  endfunction

  // Value loaded into the countdown on issue.
  function automatic logic [CNT_W-1:0] kind_load(input logic [CW-1:0] k);
    logic [LAT_W-1:0] l;
    l = kind_latency(k) - 6'd1;
    kind_load = l[CNT_W-1:0];
  endfunction

  // Cycles a consumer may start before the full latency has elapsed.
  function automatic logic [CNT_W-1:0] fwd_slack(input logic [CW-1:0] prod,
                                                 input logic [CW-1:0] cons);
    logic wide_cons;
    wide_cons = (cons == K_VMOVW) || (cons == K_VADDW);
    if (wide_cons && ((prod == K_VMOVW) || (prod == K_VADDW)))
      fwd_slack = CNT_W'(1);
    else
      fwd_slack = '0;
  endfunction

endpackage

// File: rtl/sb_entry.sv
module sb_entry
  import lat_sb_pkg::*;
#(
  parameter int NISS = 2,
  parameter int RW   = 5,
  parameter int IDX  = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NISS-1:0]               iss_vld,
  input  logic [NISS-1:0][RW-1:0]       iss_dst,
  input  logic [NISS-1:0][CW-1:0]       iss_cls,
  output logic [CNT_W-1:0]              cnt,
  output logic [CW-1:0]                 kind,
  output logic                          wr_hit,
  output logic [CW-1:0]                 wr_kind
);

  // Later lanes overwrite earlier ones: youngest writer wins.
  always_comb begin
    wr_hit  = 1'b0;
    wr_kind = K_ALU;
    for (int l = 0; l < NISS; l++) begin
      if (iss_vld[l] && (iss_dst[l] == RW'(IDX))) begin
        wr_hit  = 1'b1;
        wr_kind = iss_cls[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      kind <= K_ALU;
    end else if (wr_hit) begin
      cnt  <= kind_load(wr_kind);
      kind <= wr_kind;
    end else if (cnt != '0) begin
      cnt  <= cnt - CNT_W'(1);
    end
  end

endmodule

// File: rtl/sb_query.sv
module sb_query
  import lat_sb_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int NSRC  = 4,
  parameter int RW    = 5
) (
  input  logic [NREGS-1:0][CNT_W-1:0] cnt_vec,
  input  logic [NREGS-1:0][CW-1:0]    kind_vec,
  input  logic [NSRC-1:0]             src_vld,
  input  logic [NSRC-1:0][RW-1:0]     src_reg,
  input  logic [NSRC-1:0][CW-1:0]     src_cls,
  output logic [NSRC-1:0]             src_rdy
);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [CNT_W-1:0] rem;
    logic [CW-1:0]    pk;
    always_comb begin
      rem = cnt_vec[src_reg[s]];
      pk  = kind_vec[src_reg[s]];
      if (!src_vld[s] || (src_reg[s] == '0))
        src_rdy[s] = 1'b1;
      else
        src_rdy[s] = (rem <= fwd_slack(pk, src_cls[s]));
    end
  end

endmodule

// File: rtl/cls_lat_scoreboard.sv
module cls_lat_scoreboard
  import lat_sb_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int NISS  = 2,
  parameter int NSRC  = 4,
  localparam int RW   = $clog2(NREGS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NISS-1:0]         iss_vld,
  input  logic [NISS-1:0][RW-1:0] iss_dst,
  input  logic [NISS-1:0][CW-1:0] iss_cls,
  input  logic [NSRC-1:0]         src_vld,
  input  logic [NSRC-1:0][RW-1:0] src_reg,
  input  logic [NSRC-1:0][CW-1:0] src_cls,
  output logic [NSRC-1:0]         src_rdy,
  output logic                    stall
);

  // Named internal events, observed by the bound checker.
  logic [NREGS-1:0][CNT_W-1:0] cnt_vec;
  logic [NREGS-1:0][CW-1:0]    kind_vec;
  logic [NREGS-1:0]            wr_hit;
  logic [NREGS-1:0][CW-1:0]    wr_kind;

  // Register 0 is hard-wired: never pending.
  assign cnt_vec[0]  = '0;
  assign kind_vec[0] = K_ALU;
  assign wr_hit[0]   = 1'b0;
  assign wr_kind[0]  = K_ALU;

  for (genvar r = 1; r < NREGS; r++) begin : g_reg
    sb_entry #(.NISS(NISS), .RW(RW), .IDX(r)) u_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .iss_vld (iss_vld),
      .iss_dst (iss_dst),
      .iss_cls (iss_cls),
      .cnt     (cnt_vec[r]),
      .kind    (kind_vec[r]),
      .wr_hit  (wr_hit[r]),
      .wr_kind (wr_kind[r])
    );
  end

  sb_query #(.NREGS(NREGS), .NSRC(NSRC), .RW(RW)) u_query (
    .cnt_vec  (cnt_vec),
    .kind_vec (kind_vec),
    .src_vld  (src_vld),
    .src_reg  (src_reg),
    .src_cls  (src_cls),
    .src_rdy  (src_rdy)
  );

  assign stall = ~&src_rdy;

endmodule

// File: rtl/sb_checker.sv
module sb_checker
  import lat_sb_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int NISS  = 2,
  parameter int NSRC  = 4,
  parameter int RW    = 5
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NISS-1:0]             iss_vld,
  input logic [NISS-1:0][RW-1:0]     iss_dst,
  input logic [NISS-1:0][CW-1:0]     iss_cls,
  input logic [NSRC-1:0]             src_vld,
  input logic [NSRC-1:0][RW-1:0]     src_reg,
  input logic [NSRC-1:0]             src_rdy,
  input logic                        stall,
  input logic [NREGS-1:0][CNT_W-1:0] cnt_vec,
  input logic [NREGS-1:0]            wr_hit,
  input logic [NREGS-1:0][CW-1:0]    wr_kind
);

  for (genvar r = 1; r < NREGS; r++) begin : g_chk
    // R2: issue loads latency minus one
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[r] |=> cnt_vec[r] == kind_load($past(wr_kind[r])));
    // R2: countdown falls by one per idle cycle
    a_r2_count: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit[r] && cnt_vec[r] != '0) |=> cnt_vec[r] == $past(cnt_vec[r]) - CNT_W'(1));
    // R2: an expired entry stays at zero
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit[r] && cnt_vec[r] == '0) |=> cnt_vec[r] == '0);
    // R8: the highest lane's class decides
    a_r8_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_vld[NISS-1] && iss_dst[NISS-1] == RW'(r))
        |=> cnt_vec[r] == kind_load($past(iss_cls[NISS-1])));
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    // R6: register 0 always ready
    a_r6_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
      (src_vld[s] && src_reg[s] == '0) |-> src_rdy[s]);
    // R7: invalid queries never block
    a_r7_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      !src_vld[s] |-> src_rdy[s]);
  end

  // R9: stall asserted only with a blocked query
  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ($countones(src_rdy) < NSRC));
  a_r9_nostall: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |-> ($countones(src_rdy) == NSRC));

endmodule

bind cls_lat_scoreboard sb_checker #(
  .NREGS(NREGS), .NISS(NISS), .NSRC(NSRC), .RW(RW)
) u_sb_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .iss_vld (iss_vld),
  .iss_dst (iss_dst),
  .iss_cls (iss_cls),
  .src_vld (src_vld),
  .src_reg (src_reg),
  .src_rdy (src_rdy),
  .stall   (stall),
  .cnt_vec (cnt_vec),
  .wr_hit  (wr_hit),
  .wr_kind (wr_kind)
);

// File: tb/test_cls_lat_scoreboard.sv
module test_cls_lat_scoreboard;

  localparam int NREGS = 32;
  localparam int NISS  = 2;
  localparam int NSRC  = 4;
  localparam int RW    = 5;
  localparam int CW    = 5;

  // {producer code, consumer code, cycles until ready}
  localparam int NV = 28;
  localparam logic [15:0] VEC [NV] = '{
    {5'd0,  5'd0, 6'd1},  {5'd1,  5'd0, 6'd2},  {5'd2,  5'd0, 6'd2},
    {5'd3,  5'd0, 6'd4},  {5'd4,  5'd0, 6'd22}, {5'd5,  5'd0, 6'd3},
    {5'd6,  5'd0, 6'd4},  {5'd7,  5'd0, 6'd4},  {5'd8,  5'd0, 6'd4},
    {5'd9,  5'd0, 6'd6},  {5'd10, 5'd0, 6'd6},  {5'd11, 5'd0, 6'd2},
    {5'd12, 5'd0, 6'd4},  {5'd13, 5'd0, 6'd12}, {5'd14, 5'd0, 6'd22},
    {5'd15, 5'd0, 6'd17}, {5'd16, 5'd0, 6'd28}, {5'd17, 5'd0, 6'd2},
    {5'd18, 5'd0, 6'd3},  {5'd19, 5'd0, 6'd4},  {5'd20, 5'd0, 6'd5},
    {5'd18, 5'd18, 6'd2}, {5'd18, 5'd20, 6'd2}, {5'd20, 5'd18, 6'd4},
    {5'd20, 5'd20, 6'd4}, {5'd20, 5'd19, 6'd5}, {5'd17, 5'd18, 6'd2},
    {5'd31, 5'd0, 6'd1}
  };

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic [NISS-1:0]         iss_vld;
  logic [NISS-1:0][RW-1:0] iss_dst;
  logic [NISS-1:0][CW-1:0] iss_cls;
  logic [NSRC-1:0]         src_vld;
  logic [NSRC-1:0][RW-1:0] src_reg;
  logic [NSRC-1:0][CW-1:0] src_cls;
  logic [NSRC-1:0]         src_rdy;
  logic                    stall;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  cls_lat_scoreboard #(.NREGS(NREGS), .NISS(NISS), .NSRC(NSRC)) i_cls_lat_scoreboard (
    .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_dst(iss_dst), .iss_cls(iss_cls),
    .src_vld(src_vld), .src_reg(src_reg), .src_cls(src_cls),
    .src_rdy(src_rdy), .stall(stall)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h (t=%0t)", req, got, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drive one issue on a lane at a negedge; returns in cycle issue+1.
  task automatic issue(input int lane, input int dst, input int kc);
    iss_vld[lane] = 1'b1;
    iss_dst[lane] = RW'(dst);
    iss_cls[lane] = CW'(kc);
    @(negedge clk);
    iss_vld = '0;
  endtask

  task automatic q0(input int r, input int kc);
    src_vld    = 4'b0001;
    src_reg[0] = RW'(r);
    src_cls[0] = CW'(kc);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected < 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; iss_vld = '0; iss_dst = '0; iss_cls = '0;
    src_vld = '0; src_reg = '0; src_cls = '0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    src_vld = 4'b1111;
    src_reg = {5'd4, 5'd3, 5'd2, 5'd1};
    #1;
    chk("R1 rdy", src_rdy, 4'b1111);
    chk("R1 stall", stall, 0);

    // R2/R3/R5: table walk on register 5, query slot 0
    for (int v = 0; v < NV; v++) begin
      logic [4:0] pc, cc;
      int eff;
      pc  = VEC[v][15:11];
      cc  = VEC[v][10:6];
      eff = int'(VEC[v][5:0]);
      q0(5, int'(cc));
      issue(0, 5, int'(pc));
      for (int d = 1; d <= eff; d++) begin
        if (d == eff - 1) begin
          chk($sformatf("R2/R3/R5 early p%0d c%0d", pc, cc), src_rdy[0], 0);
          chk("R9 stall while blocked", stall, 1);
        end
        if (d == eff) begin
          chk($sformatf("R2/R3/R5 ready p%0d c%0d", pc, cc), src_rdy[0], 1);
        end
        if (d < eff) @(negedge clk);
      end
      idle(2);
    end

    // R4: shorter overwrite (divide, then ALU two cycles later)
    q0(3, 0);
    issue(0, 3, 4);
    idle(1);
    issue(1, 3, 0);
    chk("R4 shorter overwrite", src_rdy[0], 1);
    // R4: longer overwrite (load, then multiply next cycle)
    q0(4, 0);
    issue(0, 4, 5);
    issue(0, 4, 3);
    idle(2);
    chk("R4 longer overwrite d3", src_rdy[0], 0);
    idle(1);
    chk("R4 longer overwrite d4", src_rdy[0], 1);

    // R8: both lanes same destination
    q0(6, 0);
    iss_vld = 2'b11; iss_dst = {5'd6, 5'd6}; iss_cls = {5'd0, 5'd4};
    @(negedge clk); iss_vld = '0;
    chk("R8 lane1 ALU wins", src_rdy[0], 1);
    iss_vld = 2'b11; iss_dst = {5'd6, 5'd6}; iss_cls = {5'd4, 5'd0};
    @(negedge clk); iss_vld = '0;
    chk("R8 lane1 divide wins", src_rdy[0], 0);

    // R7: invalid query to pending register 6
    src_vld = 4'b0000; src_reg[0] = 5'd6;
    #1;
    chk("R7 invalid ready", src_rdy[0], 1);
    chk("R7 no stall", stall, 0);

    // R6: issue to register 0 has no effect
    issue(0, 0, 16);
    q0(0, 0);
    #1;
    chk("R6 reg0 ready", src_rdy[0], 1);

    // R9: mixed sources, register 9 pending with divide
    issue(0, 9, 4);
    src_vld = 4'b1101;
    src_reg = {5'd8, 5'd9, 5'd2, 5'd0};
    src_cls = '0;
    #1;
    chk("R9 rdy pattern", src_rdy, 4'b1011);
    chk("R9 stall", stall, 1);
    src_vld = 4'b1001;
    #1;
    chk("R9 no stall", stall, 0);

    idle(30);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule